// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits next to a small processor core and carries an external interrupt from the request pins to the point where the core can jump to the service routine. It watches two request lines. The first is a maskable line that is level-sensitive and active high. The second is a non-maskable line that reacts to its rising edge. Both lines are synchronised to the clock before any logic uses them. The block holds the interrupt-enable flag and the single-step trap flag. The core sets and clears these flags through command strobes.

When the core signals an instruction boundary and a request can be taken, the block runs a fixed sequence:

1. For a maskable request only, it drives two active-low acknowledge pulses and latches an 8-bit type code from the data bus during the second pulse.
2. It pushes the flags word to the stack.
3. It clears the enable and trap flags.
4. It pushes the return code segment, then the return instruction pointer.
5. It reads the new instruction pointer and code segment from the vector table.
6. It presents the two values with a one-cycle load strobe.

A non-maskable request skips the acknowledge pulses and uses type code 2.

Top module: `irq_ack_seq`

## Requirements
- R1: A maskable request with the enable flag at 1 starts an acknowledge only when `boundary_i` is high. While the boundary strobe stays low, `ack_n_o` remains 1 and `busy_o` remains 0.
- R2: While the enable flag is 0, a maskable request has no effect: no acknowledge pulse, no push, no read.
- R3: After reset, both the enable flag and the trap flag are 0. A set strobe drives its flag to 1 on the next cycle and a clear strobe drives it to 0. When set and clear arrive in the same cycle, clear wins.
- R4: A maskable acknowledge is two low pulses on `ack_n_o`, each ACK_LOW cycles long, with ACK_GAP high cycles between them. The type code is taken from `type_bus_i` in the last cycle of the second pulse. Any value on the bus during the first pulse is ignored.
- R5: The first push is the flags word. It equals `core_flags_i` with bit 9 replaced by the enable flag and bit 8 replaced by the trap flag, both as they stood when the request was accepted.
- R6: Once the flags push is accepted, the enable and trap flags read 0, and this holds before the code segment push is offered.
- R7: The second push is the return code segment (`ret_cs_i`) and the third is the return instruction pointer (`ret_ip_i`).
- R8: The new instruction pointer is read from byte address type*4 and the new code segment from type*4+2. Both values then appear on `new_ip_o` and `new_cs_o` while `vec_load_o` is high for one cycle.
- R9: Each push and each read holds its valid signal, address and data unchanged until the matching ready input is high.
- R10: A rising edge on `nmi_i` is serviced at the next boundary whatever the enable flag holds. It uses type code 2, produces no acknowledge pulses, and wins over a maskable request at the same boundary. A line held high does not retrigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_i | input | 1 | Maskable request, level, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable request, rising edge, asynchronous |
| boundary_i | input | 1 | Current instruction has completed |
| set_ie_i | input | 1 | Set the interrupt-enable flag |
| clr_ie_i | input | 1 | Clear the interrupt-enable flag |
| set_tf_i | input | 1 | Set the trap flag |
| clr_tf_i | input | 1 | Clear the trap flag |
| core_flags_i | input | DATA_W | Remaining flag bits from the core |
| ret_cs_i | input | DATA_W | Return code segment |
| ret_ip_i | input | DATA_W | Return instruction pointer |
| ack_n_o | output | 1 | Acknowledge, active low |
| type_bus_i | input | TYPE_W | Type code from the requesting device |
| push_valid_o | output | 1 | Stack push request |
| push_data_o | output | DATA_W | Word to push |
| push_ready_i | input | 1 | Push accepted |
| rd_valid_o | output | 1 | Vector read request |
| rd_addr_o | output | ADDR_W | Vector read byte address |
| rd_data_i | input | DATA_W | Vector read data, valid with ready |
| rd_ready_i | input | 1 | Read data valid |
| new_ip_o | output | DATA_W | Fetched instruction pointer |
| new_cs_o | output | DATA_W | Fetched code segment |
| vec_load_o | output | 1 | One-cycle strobe to load the new IP and CS |
| ie_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Trap flag |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest case to reach from the ports is a non-maskable edge and a maskable level both pending at the same boundary, with the enable flag at 1. The bench enables interrupts, raises the maskable line, then raises the non-maskable line. It waits past the synchroniser latency and only then issues a single boundary strobe. It expects no acknowledge pulses and type 2. It then keeps the non-maskable line high and issues further boundaries, which shows that neither line retriggers once the flags are cleared. A vector table of rows varies the type code, the trap flag, ready stalls and the request kind. During the first pulse the bus carries the inverted code, so a capture on the wrong pulse shows up in the read addresses.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK1,
      ST_GAP,
      ST_ACK2,
      ST_PFL,
      ST_PCS,
      ST_PIP,
      ST_RIP,
      ST_RCS,
      ST_LOAD
   } seq_st_e;

   localparam int IE_BIT_DEF = 9;
   localparam int TF_BIT_DEF = 8;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ie_i,
   input  logic clr_ie_i,
   input  logic set_tf_i,
   input  logic clr_tf_i,
   input  logic hw_clr_i,
   output logic ie_o,
   output logic tf_o
);

   logic ie_q, tf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
         tf_q <= 1'b0;
      end else begin
         if (hw_clr_i || clr_ie_i) ie_q <= 1'b0;
         else if (set_ie_i)        ie_q <= 1'b1;
         if (hw_clr_i || clr_tf_i) tf_q <= 1'b0;
         else if (set_tf_i)        tf_q <= 1'b1;
      end
   end

   assign ie_o = ie_q;
   assign tf_o = tf_q;

   // R6: hardware clear during the response lands on both flags
   p_hw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr_i |=> (!ie_q && !tf_q));

   // R3: clear strobe wins over a set strobe
   p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ie_i |=> !ie_q);

   // R3: set strobe alone takes effect next cycle
   p_set_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ie_i && !clr_ie_i && !hw_clr_i) |=> ie_q);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_ack_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int TYPE_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int ACK_LOW  = 2,
   parameter int ACK_GAP  = 2,
   parameter int NMI_TYPE = 2,
   parameter int IE_BIT   = IE_BIT_DEF,
   parameter int TF_BIT   = TF_BIT_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              mreq_i,
   input  logic              nmi_rise_i,
   input  logic              ie_i,
   input  logic              tf_i,
   input  logic [DATA_W-1:0] core_flags_i,
   input  logic [DATA_W-1:0] ret_cs_i,
   input  logic [DATA_W-1:0] ret_ip_i,
   input  logic [TYPE_W-1:0] type_bus_i,
   input  logic              push_ready_i,
   input  logic              rd_ready_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              ack_n_o,
   output logic              push_valid_o,
   output logic [DATA_W-1:0] push_data_o,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              hw_clr_o,
   output logic [DATA_W-1:0] new_ip_o,
   output logic [DATA_W-1:0] new_cs_o,
   output logic              vec_load_o,
   output logic              busy_o
);

   localparam int CNT_MAX = (ACK_LOW > ACK_GAP) ? ACK_LOW : ACK_GAP;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(ACK_LOW - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(ACK_GAP - 1);
   localparam logic [ADDR_W-1:0] CS_OFS  = ADDR_W'(2);

   generate
      if (ACK_LOW < 1 || ACK_GAP < 1) begin : g_bad_pulse
         $error("irq_seq_fsm: pulse and gap lengths must be at least 1");
      end
      if (ADDR_W < TYPE_W + 2) begin : g_bad_addr
         $error("irq_seq_fsm: ADDR_W too narrow for the vector table");
      end
      if (IE_BIT >= DATA_W || TF_BIT >= DATA_W || IE_BIT == TF_BIT) begin : g_bad_bits
         $error("irq_seq_fsm: flag bit positions invalid");
      end
      if (NMI_TYPE >= (1 << TYPE_W)) begin : g_bad_nmi
         $error("irq_seq_fsm: NMI_TYPE does not fit TYPE_W");
      end
   endgenerate

   seq_st_e             st_q, st_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic [TYPE_W-1:0]   type_q;
   logic [DATA_W-1:0]   snap_fl_q, snap_cs_q, snap_ip_q;
   logic [DATA_W-1:0]   ip_q, cs_q;
   logic                nmi_pend_q;
   logic [DATA_W-1:0]   flags_now;
   logic                take_nmi, take_mi, push_hs, rd_hs, ack2_end;
   logic [ADDR_W-1:0]   vec_base;

   assign take_nmi = (st_q == ST_IDLE) && boundary_i && nmi_pend_q;
   assign take_mi  = (st_q == ST_IDLE) && boundary_i && !nmi_pend_q && mreq_i && ie_i;
   assign push_hs  = push_valid_o && push_ready_i;
   assign rd_hs    = rd_valid_o && rd_ready_i;
   assign ack2_end = (st_q == ST_ACK2) && (cnt_q == LOW_LAST);

   always_comb begin
      flags_now         = core_flags_i;
      flags_now[IE_BIT] = ie_i;
      flags_now[TF_BIT] = tf_i;
   end

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (take_nmi)     st_d = ST_PFL;
            else if (take_mi) st_d = ST_ACK1;
         end
         ST_ACK1: begin
            if (cnt_q == LOW_LAST) begin st_d = ST_GAP; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
         end
         ST_GAP: begin
            if (cnt_q == GAP_LAST) begin st_d = ST_ACK2; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
         end
         ST_ACK2: begin
            if (cnt_q == LOW_LAST) begin st_d = ST_PFL; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
         end
         ST_PFL:  if (push_hs) st_d = ST_PCS;
         ST_PCS:  if (push_hs) st_d = ST_PIP;
         ST_PIP:  if (push_hs) st_d = ST_RIP;
         ST_RIP:  if (rd_hs)   st_d = ST_RCS;
         ST_RCS:  if (rd_hs)   st_d = ST_LOAD;
         ST_LOAD: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         type_q     <= '0;
         snap_fl_q  <= '0;
         snap_cs_q  <= '0;
         snap_ip_q  <= '0;
         ip_q       <= '0;
         cs_q       <= '0;
         nmi_pend_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (take_nmi)      type_q <= TYPE_W'(NMI_TYPE);
         else if (ack2_end) type_q <= type_bus_i;
         if (take_nmi || take_mi) begin
            snap_fl_q <= flags_now;
            snap_cs_q <= ret_cs_i;
            snap_ip_q <= ret_ip_i;
         end
         if (st_q == ST_RIP && rd_hs) ip_q <= rd_data_i;
         if (st_q == ST_RCS && rd_hs) cs_q <= rd_data_i;
         if (nmi_rise_i)    nmi_pend_q <= 1'b1;
         else if (take_nmi) nmi_pend_q <= 1'b0;
      end
   end

   assign vec_base = ADDR_W'(type_q) << 2;

   always_comb begin
      push_data_o = snap_fl_q;
      if (st_q == ST_PCS) push_data_o = snap_cs_q;
      if (st_q == ST_PIP) push_data_o = snap_ip_q;
   end

   assign ack_n_o      = !((st_q == ST_ACK1) || (st_q == ST_ACK2));
   assign push_valid_o = (st_q == ST_PFL) || (st_q == ST_PCS) || (st_q == ST_PIP);
   assign rd_valid_o   = (st_q == ST_RIP) || (st_q == ST_RCS);
   assign rd_addr_o    = (st_q == ST_RCS) ? (vec_base + CS_OFS) : vec_base;
   assign hw_clr_o     = (st_q == ST_PFL) && push_ready_i;
   assign vec_load_o   = (st_q == ST_LOAD);
   assign busy_o       = (st_q != ST_IDLE);
   assign new_ip_o     = ip_q;
   assign new_cs_o     = cs_q;

   // R9: a stalled push keeps its word
   p_push_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

   // R9: a stalled read keeps its address
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

   // R8: vector reads are word aligned
   p_rd_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !rd_addr_o[0]);

   // R4: no acknowledge outside a sequence
   p_ack_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ack_n_o);

   // R8: load strobe lasts a single cycle
   p_load_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_load_o |=> !vec_load_o);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int TYPE_W      = 8,
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_LOW     = 2,
   parameter int ACK_GAP     = 2,
   parameter int NMI_TYPE    = 2,
   parameter int IE_BIT      = IE_BIT_DEF,
   parameter int TF_BIT      = TF_BIT_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mreq_i,
   input  logic              nmi_i,
   input  logic              boundary_i,
   input  logic              set_ie_i,
   input  logic              clr_ie_i,
   input  logic              set_tf_i,
   input  logic              clr_tf_i,
   input  logic [DATA_W-1:0] core_flags_i,
   input  logic [DATA_W-1:0] ret_cs_i,
   input  logic [DATA_W-1:0] ret_ip_i,
   output logic              ack_n_o,
   input  logic [TYPE_W-1:0] type_bus_i,
   output logic              push_valid_o,
   output logic [DATA_W-1:0] push_data_o,
   input  logic              push_ready_i,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_ready_i,
   output logic [DATA_W-1:0] new_ip_o,
   output logic [DATA_W-1:0] new_cs_o,
   output logic              vec_load_o,
   output logic              ie_o,
   output logic              tf_o,
   output logic              busy_o
);

   logic [1:0] req_s;
   logic       nmi_prev_q, nmi_rise, hw_clr;

   irq_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({nmi_i, mreq_i}),
      .q_o   (req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_prev_q <= 1'b0;
      else        nmi_prev_q <= req_s[1];
   end
   assign nmi_rise = req_s[1] && !nmi_prev_q;

   irq_flag_reg u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ie_i (set_ie_i),
      .clr_ie_i (clr_ie_i),
      .set_tf_i (set_tf_i),
      .clr_tf_i (clr_tf_i),
      .hw_clr_i (hw_clr),
      .ie_o     (ie_o),
      .tf_o     (tf_o)
   );

   irq_seq_fsm #(
      .DATA_W   (DATA_W),
      .TYPE_W   (TYPE_W),
      .ADDR_W   (ADDR_W),
      .ACK_LOW  (ACK_LOW),
      .ACK_GAP  (ACK_GAP),
      .NMI_TYPE (NMI_TYPE),
      .IE_BIT   (IE_BIT),
      .TF_BIT   (TF_BIT)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .boundary_i   (boundary_i),
      .mreq_i       (req_s[0]),
      .nmi_rise_i   (nmi_rise),
      .ie_i         (ie_o),
      .tf_i         (tf_o),
      .core_flags_i (core_flags_i),
      .ret_cs_i     (ret_cs_i),
      .ret_ip_i     (ret_ip_i),
      .type_bus_i   (type_bus_i),
      .push_ready_i (push_ready_i),
      .rd_ready_i   (rd_ready_i),
      .rd_data_i    (rd_data_i),
      .ack_n_o      (ack_n_o),
      .push_valid_o (push_valid_o),
      .push_data_o  (push_data_o),
      .rd_valid_o   (rd_valid_o),
      .rd_addr_o    (rd_addr_o),
      .hw_clr_o     (hw_clr),
      .new_ip_o     (new_ip_o),
      .new_cs_o     (new_cs_o),
      .vec_load_o   (vec_load_o),
      .busy_o       (busy_o)
   );

   // R2: an acknowledge only begins when the enable flag was set
   p_ack_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ack_n_o) && !$past(busy_o)) |-> $past(ie_o));

   // R6: no push beyond the flags word while the enable flag is still set
   p_ie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && $past(push_valid_o) && $changed(push_data_o)) |-> !ie_o);

endmodule

// File: tb/sim_irq_ack_seq.sv
module sim_irq_ack_seq;

   localparam int DW = 16;
   localparam int TW = 8;
   localparam int AW = 16;
   localparam int LOWC = 2;
   localparam int GAPC = 2;
   localparam int NROW = 5;

   // row: [26] nmi, [25] trap preset, [24] stall, [23:16] code, [15:0] core flags
   localparam logic [26:0] ROWS [NROW] = '{
      {1'b0, 1'b0, 1'b0, 8'h08, 16'h0002},
      {1'b0, 1'b1, 1'b1, 8'hFF, 16'hF0D5},
      {1'b1, 1'b0, 1'b0, 8'h02, 16'h0046},
      {1'b0, 1'b0, 1'b1, 8'h00, 16'h0FFF},
      {1'b1, 1'b1, 1'b1, 8'h02, 16'h8001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mreq = 0, nmi = 0, bnd = 0, sie = 0, cie = 0, stf = 0, ctf = 0;
   logic [DW-1:0] cflags = '0, rcs = '0, rip = '0, rdat = '0;
   logic [TW-1:0] tbus = '0;
   logic pready = 0, rready = 0;
   logic ack_n, pvalid, rvalid, vload, ie, tf, busy;
   logic [DW-1:0] pdata, nip, ncs;
   logic [AW-1:0] raddr;

   int errors = 0;
   int checks = 0;
   int cyc_total = 0;

   // collected by the responder
   logic [DW-1:0] pushes [3];
   int            npush;
   logic [AW-1:0] raddrs [2];
   int            nrd;
   int            npulse, low1, gap1, low2;
   logic          ie_at_cs, tf_at_cs, got_load;
   logic [DW-1:0] got_ip, got_cs;

   always #5 clk = ~clk;

   irq_ack_seq #(.DATA_W(DW), .TYPE_W(TW), .ADDR_W(AW), .ACK_LOW(LOWC), .ACK_GAP(GAPC)) u0 (
      .clk(clk), .rst_n(rst_n), .mreq_i(mreq), .nmi_i(nmi), .boundary_i(bnd),
      .set_ie_i(sie), .clr_ie_i(cie), .set_tf_i(stf), .clr_tf_i(ctf),
      .core_flags_i(cflags), .ret_cs_i(rcs), .ret_ip_i(rip),
      .ack_n_o(ack_n), .type_bus_i(tbus),
      .push_valid_o(pvalid), .push_data_o(pdata), .push_ready_i(pready),
      .rd_valid_o(rvalid), .rd_addr_o(raddr), .rd_data_i(rdat), .rd_ready_i(rready),
      .new_ip_o(nip), .new_cs_o(ncs), .vec_load_o(vload),
      .ie_o(ie), .tf_o(tf), .busy_o(busy)
   );

   function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
      return (DW'(a) * 16'h0101) ^ 16'h5A3C;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input bit s_ie, input bit c_ie, input bit s_tf, input bit c_tf);
      @(negedge clk);
      sie = s_ie; cie = c_ie; stf = s_tf; ctf = c_tf;
      @(negedge clk);
      sie = 0; cie = 0; stf = 0; ctf = 0;
   endtask

   task automatic boundary_pulse();
      @(negedge clk);
      bnd = 1;
      @(negedge clk);
      bnd = 0;
   endtask

   // acts as device, stack and memory; samples at falling edges
   task automatic respond(input logic [TW-1:0] code, input bit stall);
      logic prev_ack = 1'b1;
      npush = 0; nrd = 0; npulse = 0; low1 = 0; gap1 = 0; low2 = 0;
      got_load = 0; ie_at_cs = 1'b1; tf_at_cs = 1'b1;
      for (int c = 0; c < 400 && !got_load; c++) begin
         if (!ack_n) begin
            if (prev_ack) npulse++;
            if (npulse == 1) low1++;
            else if (npulse == 2) low2++;
         end else if (npulse == 1) begin
            gap1++;
         end
         prev_ack = ack_n;
         tbus = (!ack_n && npulse == 2) ? code : ~code;
         pready = pvalid && (!stall || (c % 3 == 2));
         if (pvalid && pready) begin
            if (npush < 3) pushes[npush] = pdata;
            if (npush == 1) begin ie_at_cs = ie; tf_at_cs = tf; end
            npush++;
         end
         rready = rvalid && (!stall || (c % 3 == 1));
         rdat = memv(raddr);
         if (rvalid && rready) begin
            if (nrd < 2) raddrs[nrd] = raddr;
            nrd++;
         end
         if (vload) begin
            got_load = 1; got_ip = nip; got_cs = ncs;
         end
         @(negedge clk);
      end
      pready = 0; rready = 0;
   endtask

   task automatic quiet_window(input string req, input int n);
      bit seen = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         if (!ack_n || busy || pvalid || rvalid) seen = 1;
      end
      chk(!seen, req, {31'd0, seen}, 32'd0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_total++;
         if (cyc_total > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3: reset state
      chk(ie == 0 && tf == 0, "R3 reset flags", {30'd0, ie, tf}, 0);
      chk(ack_n == 1 && !busy && !pvalid && !rvalid, "R3 reset outputs",
          {28'd0, ack_n, busy, pvalid, rvalid}, 32'h8);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // vector table walk
      for (int i = 0; i < NROW; i++) begin
         logic is_nmi, tfp, stl;
         logic [TW-1:0] code;
         logic [DW-1:0] expf, ecs, eip;
         logic [AW-1:0] base;
         {is_nmi, tfp, stl, code, cflags} = ROWS[i];
         rcs = 16'h1000 + DW'(i) * 16'h0111;
         rip = 16'h0200 + DW'(i) * 16'h0003;
         cmd(0, 1, 0, 1);
         if (!is_nmi) cmd(1, 0, 0, 0);
         if (tfp) cmd(0, 0, 1, 0);
         if (is_nmi) nmi = 1; else mreq = 1;
         repeat (4) @(negedge clk);
         @(negedge clk); bnd = 1;
         @(negedge clk); bnd = 0;
         respond(code, stl);
         mreq = 0; nmi = 0;
         expf = cflags; expf[9] = !is_nmi; expf[8] = tfp;
         ecs = rcs; eip = rip;
         base = AW'(code) << 2;
         chk(got_load, "R8 load strobe", {31'd0, got_load}, 1);
         if (is_nmi) chk(npulse == 0, "R10 no acknowledge pulses", npulse, 0);
         else begin
            chk(npulse == 2, "R4 pulse count", npulse, 2);
            chk(low1 == LOWC && gap1 == GAPC && low2 == LOWC, "R4 pulse timing",
                {low1[7:0], gap1[7:0], low2[7:0]}, {8'(LOWC), 8'(GAPC), 8'(LOWC)});
         end
         chk(npush == 3, "R9 push count", npush, 3);
         chk(pushes[0] == expf, "R5 flags word", pushes[0], expf);
         chk(ie_at_cs == 0 && tf_at_cs == 0, "R6 flags cleared before CS push",
             {30'd0, ie_at_cs, tf_at_cs}, 0);
         chk(pushes[1] == ecs, "R7 CS push", pushes[1], ecs);
         chk(pushes[2] == eip, "R7 IP push", pushes[2], eip);
         chk(nrd == 2 && raddrs[0] == base && raddrs[1] == base + 2, "R8 vector addresses",
             {raddrs[0], raddrs[1]}, {base, base + AW'(2)});
         chk(got_ip == memv(base) && got_cs == memv(base + 2), "R8 new IP/CS",
             {got_ip, got_cs}, {memv(base), memv(base + 2)});
         repeat (4) @(negedge clk);
      end

      // R2: enable off, request ignored even at boundaries
      cmd(0, 1, 0, 0);
      mreq = 1;
      repeat (4) @(negedge clk);
      boundary_pulse();
      quiet_window("R2 masked request ignored", 20);
      boundary_pulse();
      quiet_window("R2 masked request ignored again", 10);

      // R1: enabled request waits for the boundary
      cmd(1, 0, 0, 0);
      quiet_window("R1 no boundary no acknowledge", 20);
      @(negedge clk); bnd = 1;
      @(negedge clk); bnd = 0;
      respond(8'h31, 0);
      chk(npulse == 2 && got_load, "R1 taken at boundary", npulse, 2);
      mreq = 0;
      repeat (4) @(negedge clk);

      // R3: set and clear together, clear wins
      cmd(1, 0, 1, 0);
      chk(ie && tf, "R3 set strobes", {30'd0, ie, tf}, 3);
      cmd(1, 1, 1, 1);
      chk(!ie && !tf, "R3 clear wins", {30'd0, ie, tf}, 0);

      // R10: NMI wins over a pending maskable request at one boundary
      cmd(1, 0, 0, 0);
      cflags = 16'h0000; rcs = 16'hBEEF; rip = 16'h1234;
      mreq = 1;
      nmi = 1;
      repeat (4) @(negedge clk);
      @(negedge clk); bnd = 1;
      @(negedge clk); bnd = 0;
      respond(8'h77, 0);
      chk(npulse == 0, "R10 priority over maskable", npulse, 0);
      chk(raddrs[0] == 16'h0008, "R10 type code 2", raddrs[0], 16'h0008);
      chk(pushes[0][9] == 1'b1, "R10 flags snapshot", {31'd0, pushes[0][9]}, 1);
      // NMI still high, IE now clear: nothing fires
      boundary_pulse();
      quiet_window("R10 held line does not retrigger", 15);
      mreq = 0; nmi = 0;
      repeat (4) @(negedge clk);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule